// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Sequencer

This block sits between an on-chip requester and one external asynchronous static RAM. It takes single-word read or write requests and plays each one out on the external pins as a cycle built from separate phases. The pins are a word address, an active-low chip enable, an active-low output enable, an active-low write strobe and a data bus. The data bus is split into an outgoing value, a drive-enable and an incoming value, so the pad ring can build the tri-state buffer. The length of every phase is set by its own 4-bit configuration input, counted in clock cycles, so the sequencer can meet each timing minimum of the memory independently instead of padding everything with one wait count.

A write holds the address with chip enable active for the setup count. It then lowers the write strobe and drives the data, holds the data after the strobe rises, and pads the cycle out to the write-cycle minimum. A read lowers chip enable and output enable together. It samples the data bus once the longest of the three access counts has elapsed, returns the word with a one-clock valid pulse, and pads out to the read-cycle minimum. After a read, writes are held off for a turnaround count so that the memory's output drivers are off before the sequencer drives the bus.

The request side follows valid/ready rules. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. While `req_valid` is high and the request has not yet transferred, the requester keeps `req_write`, `req_addr` and `req_wdata` stable. `req_ready` depends on `req_write`, because a write may be held back during turnaround while a read is not. The completion pulse `done` and the read-return pulse `rd_valid` cannot be stalled by the requester. The configuration inputs must stay constant while a cycle is in progress.

Top module: `sram_async_ctrl`

## Requirements
- R1: While reset is active and right after it, chip enable, output enable and write strobe are all high, the data drive-enable is low, `done` and `rd_valid` are low and `req_ready` is high.
- R2: A request is taken only on an edge where `req_valid` and `req_ready` are both high. `req_ready` stays low from the first cycle of a bus cycle through the cycle in which `done` is high. `done` is high for exactly one clock, in the last cycle of every bus cycle.
- R3: A write keeps chip enable low and the address stable, with the write strobe high and the bus undriven, for the normalized address-setup count before the write strobe falls. The write strobe is never low while chip enable is high.
- R4: The write strobe stays low for the largest of three values: the normalized strobe count, the normalized data-setup count, and the normalized chip-enable minimum minus the setup count. This makes chip enable active for at least its minimum by the time the strobe rises.
- R5: The write data is driven from the cycle in which the write strobe falls. It stays driven for the normalized hold count after the strobe rises, and is then released. The driven value equals the accepted `req_wdata` throughout.
- R6: Every timing input equal to 0 acts as 1 cycle. With all inputs at 0, a write lasts 4 cycles: setup 1, strobe 1, hold 1, pad 1. A read lasts 2 cycles: access 1, pad 1.
- R7: A read holds chip enable and output enable low for N cycles, N being the largest of the normalized address-access, chip-enable-access and output-enable-access counts. The bus is sampled at the edge that ends cycle N. `rd_valid` is high for one clock in cycle N+1, with the sampled word on `rd_data`.
- R8: The address stays constant from the first cycle of a bus cycle to its last. A write lasts the larger of (setup + strobe + hold + 1) and its normalized cycle minimum. A read lasts the larger of (N + 1) and its normalized cycle minimum.
- R9: The data drive-enable is never high while output enable is low, during a read, or while idle.
- R10: After a read completes, write requests see `req_ready` low for exactly the normalized turnaround count of cycles. Read requests are accepted during that time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be taken this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| done | output | 1 | One-clock pulse in the last cycle of a bus cycle |
| rd_valid | output | 1 | One-clock pulse, read word on rd_data |
| rd_data | output | DATA_W | Captured read word |
| cfg_wr_addr_setup | input | CNT_W | Cycles of address setup before the write strobe |
| cfg_wr_strobe | input | CNT_W | Minimum write strobe width |
| cfg_wr_data_setup | input | CNT_W | Minimum data valid before the strobe rises |
| cfg_wr_data_hold | input | CNT_W | Data hold after the strobe rises |
| cfg_wr_cs_min | input | CNT_W | Minimum chip-enable time ending at the strobe rise |
| cfg_wr_cycle | input | CNT_W | Minimum write cycle length |
| cfg_rd_addr_access | input | CNT_W | Address access delay |
| cfg_rd_cs_access | input | CNT_W | Chip-enable access delay |
| cfg_rd_oe_access | input | CNT_W | Output-enable access delay |
| cfg_rd_cycle | input | CNT_W | Minimum read cycle length |
| cfg_turnaround | input | CNT_W | Write hold-off after a read |
| mem_addr | output | ADDR_W | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| mem_dq_out | output | DATA_W | Data to drive onto the bus |
| mem_dq_oe | output | 1 | Bus drive enable, active high |
| mem_dq_in | input | DATA_W | Data read from the bus |

## Verification
The bench measures every phase length from the pins and varies one limit at a time. It covers the case where the chip-enable minimum, rather than the strobe count, sets the strobe length, and the case where the data-setup count is the longest. A design that ignored either one would raise the strobe early and fail the strobe-length check. It also pads a write and a read out to long cycle minimums; a design that skipped the padding would end the cycle after its phase sum and produce a short cycle count. The memory model returns a wrong word until the required access time has passed, so a design that samples one cycle early gets bad read data. The all-zero setting catches a design that treats 0 as a zero-length phase. A write requested right after a read must wait the exact turnaround count while a read is still allowed, which catches a hold-off that is missing, one cycle off, or applied to reads.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_W_ADDR = 3'd1,
    ST_W_STRB = 3'd2,
    ST_W_HOLD = 3'd3,
    ST_R_ACC  = 3'd4,
    ST_PAD    = 3'd5
  } cyc_state_e;

  // Indices into the packed set of timing inputs
  localparam int unsigned T_W_AS  = 0;
  localparam int unsigned T_W_STB = 1;
  localparam int unsigned T_W_DS  = 2;
  localparam int unsigned T_W_DH  = 3;
  localparam int unsigned T_W_CS  = 4;
  localparam int unsigned T_W_CYC = 5;
  localparam int unsigned T_R_AA  = 6;
  localparam int unsigned T_R_CA  = 7;
  localparam int unsigned T_R_OA  = 8;
  localparam int unsigned T_R_CYC = 9;
  localparam int unsigned T_TURN  = 10;
  localparam int unsigned T_COUNT = 11;

endpackage

// File: rtl/sram_phase_limits.sv
module sram_phase_limits
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned CNT_W = 4,
  parameter int unsigned EL_W  = CNT_W + 2
) (
  input  logic [T_COUNT-1:0][CNT_W-1:0] raw_cfg,
  output logic [EL_W-1:0]               lim_addr_setup,
  output logic [EL_W-1:0]               lim_strobe,
  output logic [EL_W-1:0]               lim_cs_min,
  output logic [EL_W-1:0]               lim_hold,
  output logic [EL_W-1:0]               lim_wr_cycle,
  output logic [EL_W-1:0]               lim_rd_access,
  output logic [EL_W-1:0]               lim_rd_cycle,
  output logic [EL_W-1:0]               lim_turn
);

  localparam int unsigned PAD_W = EL_W - CNT_W;

  logic [T_COUNT-1:0][EL_W-1:0] norm;

  // A programmed zero still means one clock of the phase
  for (genvar gi = 0; gi < T_COUNT; gi++) begin : g_norm
    always_comb begin
      if (raw_cfg[gi] == '0) norm[gi] = EL_W'(1);
      else                   norm[gi] = {{PAD_W{1'b0}}, raw_cfg[gi]};
    end
  end

  function automatic logic [EL_W-1:0] max2(input logic [EL_W-1:0] a,
                                           input logic [EL_W-1:0] b);
    return (a > b) ? a : b;
  endfunction

  always_comb begin
    lim_addr_setup = norm[T_W_AS];
    lim_strobe     = max2(norm[T_W_STB], norm[T_W_DS]);
    lim_cs_min     = norm[T_W_CS];
    lim_hold       = norm[T_W_DH];
    lim_wr_cycle   = norm[T_W_CYC];
    lim_rd_access  = max2(max2(norm[T_R_AA], norm[T_R_CA]), norm[T_R_OA]);
    lim_rd_cycle   = norm[T_R_CYC];
    lim_turn       = norm[T_TURN];
  end

endmodule

// File: rtl/sram_cycle_counters.sv
module sram_cycle_counters #(
  parameter int unsigned EL_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            phase_restart,
  output logic [EL_W-1:0] phase_cnt,
  output logic [EL_W-1:0] elapsed_cnt
);

  localparam logic [EL_W-1:0] CNT_MAX = '1;

  // Both counters read 1 in the first cycle they cover and saturate
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_cnt   <= '0;
      elapsed_cnt <= '0;
    end else if (start) begin
      phase_cnt   <= EL_W'(1);
      elapsed_cnt <= EL_W'(1);
    end else begin
      if (phase_restart)          phase_cnt <= EL_W'(1);
      else if (phase_cnt != CNT_MAX) phase_cnt <= phase_cnt + 1'b1;
      if (elapsed_cnt != CNT_MAX) elapsed_cnt <= elapsed_cnt + 1'b1;
    end
  end

  assert_elapsed_runs_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!start && $past(elapsed_cnt) != CNT_MAX && $past(rst_n))
      |-> elapsed_cnt == $past(elapsed_cnt) + 1'b1 || $past(start));

endmodule

// File: rtl/sram_turnaround.sv
module sram_turnaround #(
  parameter int unsigned EL_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [EL_W-1:0] load_val,
  output logic            busy
);

  logic [EL_W-1:0] remain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            remain <= '0;
    else if (load)         remain <= load_val;
    else if (remain != '0) remain <= remain - 1'b1;
  end

  assign busy = (remain != '0);

  assert_turn_loaded_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (load && load_val != '0) |=> busy);

endmodule

// File: rtl/sram_cycle_fsm.sv
module sram_cycle_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned EL_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  input  logic            req_write,
  input  logic            turn_busy,
  input  logic [EL_W-1:0] lim_addr_setup,
  input  logic [EL_W-1:0] lim_strobe,
  input  logic [EL_W-1:0] lim_cs_min,
  input  logic [EL_W-1:0] lim_hold,
  input  logic [EL_W-1:0] lim_wr_cycle,
  input  logic [EL_W-1:0] lim_rd_access,
  input  logic [EL_W-1:0] lim_rd_cycle,
  input  logic [EL_W-1:0] phase_cnt,
  input  logic [EL_W-1:0] elapsed_cnt,
  output logic            req_ready,
  output logic            accept,
  output logic            phase_restart,
  output logic            capture,
  output logic            done,
  output logic            read_done,
  output logic            ce_n,
  output logic            oe_n,
  output logic            we_n,
  output logic            dq_oe
);

  cyc_state_e state_q, state_d;
  logic       op_write_q;

  assign req_ready = (state_q == ST_IDLE) && !(req_write && turn_busy);
  assign accept    = req_valid && req_ready;

  always_comb begin
    state_d       = state_q;
    phase_restart = 1'b0;
    capture       = 1'b0;
    done          = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) state_d = req_write ? ST_W_ADDR : ST_R_ACC;
      end
      ST_W_ADDR: begin
        if (phase_cnt >= lim_addr_setup) begin
          state_d       = ST_W_STRB;
          phase_restart = 1'b1;
        end
      end
      ST_W_STRB: begin
        if (phase_cnt >= lim_strobe && elapsed_cnt >= lim_cs_min) begin
          state_d       = ST_W_HOLD;
          phase_restart = 1'b1;
        end
      end
      ST_W_HOLD: begin
        if (phase_cnt >= lim_hold) begin
          state_d       = ST_PAD;
          phase_restart = 1'b1;
        end
      end
      ST_R_ACC: begin
        if (elapsed_cnt >= lim_rd_access) begin
          state_d       = ST_PAD;
          phase_restart = 1'b1;
          capture       = 1'b1;
        end
      end
      ST_PAD: begin
        if (elapsed_cnt >= (op_write_q ? lim_wr_cycle : lim_rd_cycle)) begin
          state_d = ST_IDLE;
          done    = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign read_done = done && !op_write_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      op_write_q <= 1'b0;
      ce_n       <= 1'b1;
      oe_n       <= 1'b1;
      we_n       <= 1'b1;
      dq_oe      <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) op_write_q <= req_write;
      // Strobes come straight from flops, decoded from the next state
      ce_n  <= !(state_d inside {ST_W_ADDR, ST_W_STRB, ST_W_HOLD, ST_R_ACC});
      oe_n  <= (state_d != ST_R_ACC);
      we_n  <= (state_d != ST_W_STRB);
      dq_oe <= (state_d inside {ST_W_STRB, ST_W_HOLD});
    end
  end

  assert_ready_only_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ce_n |-> !req_ready);

  assert_strobe_after_setup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(we_n) |-> $past(!ce_n) && $past(!dq_oe));

endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned CNT_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              done,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data,
  input  logic [CNT_W-1:0]  cfg_wr_addr_setup,
  input  logic [CNT_W-1:0]  cfg_wr_strobe,
  input  logic [CNT_W-1:0]  cfg_wr_data_setup,
  input  logic [CNT_W-1:0]  cfg_wr_data_hold,
  input  logic [CNT_W-1:0]  cfg_wr_cs_min,
  input  logic [CNT_W-1:0]  cfg_wr_cycle,
  input  logic [CNT_W-1:0]  cfg_rd_addr_access,
  input  logic [CNT_W-1:0]  cfg_rd_cs_access,
  input  logic [CNT_W-1:0]  cfg_rd_oe_access,
  input  logic [CNT_W-1:0]  cfg_rd_cycle,
  input  logic [CNT_W-1:0]  cfg_turnaround,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic [DATA_W-1:0] mem_dq_out,
  output logic              mem_dq_oe,
  input  logic [DATA_W-1:0] mem_dq_in
);

  localparam int unsigned EL_W = CNT_W + 2;

  logic [T_COUNT-1:0][CNT_W-1:0] raw_cfg;
  logic [EL_W-1:0] lim_as, lim_stb, lim_cs, lim_dh, lim_wc, lim_ra, lim_rc, lim_tn;
  logic [EL_W-1:0] phase_cnt, elapsed_cnt;
  logic accept, phase_restart, capture, read_done, turn_busy;

  always_comb begin
    raw_cfg          = '0;
    raw_cfg[T_W_AS]  = cfg_wr_addr_setup;
    raw_cfg[T_W_STB] = cfg_wr_strobe;
    raw_cfg[T_W_DS]  = cfg_wr_data_setup;
    raw_cfg[T_W_DH]  = cfg_wr_data_hold;
    raw_cfg[T_W_CS]  = cfg_wr_cs_min;
    raw_cfg[T_W_CYC] = cfg_wr_cycle;
    raw_cfg[T_R_AA]  = cfg_rd_addr_access;
    raw_cfg[T_R_CA]  = cfg_rd_cs_access;
    raw_cfg[T_R_OA]  = cfg_rd_oe_access;
    raw_cfg[T_R_CYC] = cfg_rd_cycle;
    raw_cfg[T_TURN]  = cfg_turnaround;
  end

  sram_phase_limits #(.CNT_W(CNT_W), .EL_W(EL_W)) u_limits (
    .raw_cfg        (raw_cfg),
    .lim_addr_setup (lim_as),
    .lim_strobe     (lim_stb),
    .lim_cs_min     (lim_cs),
    .lim_hold       (lim_dh),
    .lim_wr_cycle   (lim_wc),
    .lim_rd_access  (lim_ra),
    .lim_rd_cycle   (lim_rc),
    .lim_turn       (lim_tn)
  );

  sram_cycle_counters #(.EL_W(EL_W)) u_counters (
    .clk           (clk),
    .rst_n         (rst_n),
    .start         (accept),
    .phase_restart (phase_restart),
    .phase_cnt     (phase_cnt),
    .elapsed_cnt   (elapsed_cnt)
  );

  sram_turnaround #(.EL_W(EL_W)) u_turn (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (read_done),
    .load_val (lim_tn),
    .busy     (turn_busy)
  );

  sram_cycle_fsm #(.EL_W(EL_W)) u_fsm (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .turn_busy      (turn_busy),
    .lim_addr_setup (lim_as),
    .lim_strobe     (lim_stb),
    .lim_cs_min     (lim_cs),
    .lim_hold       (lim_dh),
    .lim_wr_cycle   (lim_wc),
    .lim_rd_access  (lim_ra),
    .lim_rd_cycle   (lim_rc),
    .phase_cnt      (phase_cnt),
    .elapsed_cnt    (elapsed_cnt),
    .req_ready      (req_ready),
    .accept         (accept),
    .phase_restart  (phase_restart),
    .capture        (capture),
    .done           (done),
    .read_done      (read_done),
    .ce_n           (mem_ce_n),
    .oe_n           (mem_oe_n),
    .we_n           (mem_we_n),
    .dq_oe          (mem_dq_oe)
  );

  // Address and write word are latched once per cycle and held to its end
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr   <= '0;
      mem_dq_out <= '0;
    end else if (accept) begin
      mem_addr   <= req_addr;
      mem_dq_out <= req_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid <= 1'b0;
      rd_data  <= '0;
    end else begin
      rd_valid <= capture;
      if (capture) rd_data <= mem_dq_in;
    end
  end

  assert_we_inside_ce_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);

  assert_no_bus_fight_R9: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  assert_addr_held_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  assert_done_one_clock_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_rd_after_oe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> $past(!mem_oe_n) && mem_oe_n);

  assert_no_write_in_turn_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && req_write) |-> !turn_busy);

endmodule

// File: tb/sram_async_ctrl_test.sv
module sram_async_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 16;
  localparam int DW = 16;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic req_ready, done, rd_valid;
  logic [DW-1:0] rd_data;
  logic [CW-1:0] c_as = '0, c_stb = '0, c_ds = '0, c_dh = '0, c_cs = '0, c_wc = '0;
  logic [CW-1:0] c_aa = '0, c_ca = '0, c_oa = '0, c_rc = '0, c_tn = '0;
  logic [AW-1:0] mem_addr;
  logic mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_out, mem_dq_in;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // Memory model: 16 words, data good only after need_acc access cycles
  logic [DW-1:0] mem [16];
  int acc_cnt = 0;
  int need_acc = 1;

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    if (!mem_we_n && mem_dq_oe) mem[mem_addr[3:0]] <= mem_dq_out;
    acc_cnt <= (!mem_ce_n && !mem_oe_n) ? acc_cnt + 1 : 0;
  end

  assign mem_dq_in = (!mem_ce_n && !mem_oe_n && acc_cnt >= need_acc - 1)
                     ? mem[mem_addr[3:0]] : 16'hBAD0;

  sram_async_ctrl #(.ADDR_W(AW), .DATA_W(DW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .done(done), .rd_valid(rd_valid), .rd_data(rd_data),
    .cfg_wr_addr_setup(c_as), .cfg_wr_strobe(c_stb), .cfg_wr_data_setup(c_ds),
    .cfg_wr_data_hold(c_dh), .cfg_wr_cs_min(c_cs), .cfg_wr_cycle(c_wc),
    .cfg_rd_addr_access(c_aa), .cfg_rd_cs_access(c_ca), .cfg_rd_oe_access(c_oa),
    .cfg_rd_cycle(c_rc), .cfg_turnaround(c_tn),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_dq_out(mem_dq_out), .mem_dq_oe(mem_dq_oe),
    .mem_dq_in(mem_dq_in)
  );

  function automatic int nz(input logic [CW-1:0] v);
    return (v == 0) ? 1 : int'(v);
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic set_cfg_w(input int as_, stb, ds, dh, cs, wc);
    c_as = CW'(as_); c_stb = CW'(stb); c_ds = CW'(ds);
    c_dh = CW'(dh); c_cs = CW'(cs); c_wc = CW'(wc);
  endtask

  task automatic set_cfg_r(input int aa, ca, oa, rc, tn);
    c_aa = CW'(aa); c_ca = CW'(ca); c_oa = CW'(oa); c_rc = CW'(rc); c_tn = CW'(tn);
  endtask

  // Present a request and leave it once taken; returns in bus cycle 1
  task automatic issue(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    @(negedge clk);
    req_write = wr; req_addr = a; req_wdata = d; req_valid = 1'b1;
    for (int g = 0; g < 50 && !req_ready; g++) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // Measure a write from the pins, starting in bus cycle 1
  task automatic measure_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                               input string tag);
    int s = 0, w = 0, h = 0, cyc = 0, bad_a = 0, bad_d = 0, rdy = 0, oe = 0;
    bit seen = 0;
    int es, ew, eh;
    es = nz(c_as);
    ew = imax(imax(nz(c_stb), nz(c_ds)), nz(c_cs) - es);
    eh = nz(c_dh);
    for (int k = 0; k < 100; k++) begin
      cyc++;
      if (mem_addr !== a) bad_a++;
      if (req_ready) rdy++;
      if (!mem_oe_n) oe++;
      if (!mem_we_n) begin
        w++;
        if (mem_dq_out !== d || !mem_dq_oe) bad_d++;
      end else if (mem_dq_oe) begin
        h++;
        if (mem_dq_out !== d) bad_d++;
      end else if (!mem_ce_n) s++;
      if (done) begin seen = 1; break; end
      @(negedge clk);
    end
    chk("R3", {tag, " setup cycles"}, s, es);
    chk("R4", {tag, " strobe cycles"}, w, ew);
    chk("R5", {tag, " hold cycles"}, h, eh);
    chk("R5", {tag, " data mismatches"}, bad_d, 0);
    chk("R8", {tag, " cycle length"}, cyc, imax(es + ew + eh + 1, nz(c_wc)));
    chk("R8", {tag, " address changes"}, bad_a, 0);
    chk("R2", {tag, " ready during cycle"}, rdy, 0);
    chk("R9", {tag, " output enable in write"}, oe, 0);
    chk("R2", {tag, " done seen"}, int'(seen), 1);
    @(negedge clk);
    chk("R2", {tag, " done one clock"}, int'(done), 0);
  endtask

  // Measure a read; leaves the bench in the first cycle after done
  task automatic measure_read(input logic [AW-1:0] a, input logic [DW-1:0] expd,
                              input string tag);
    int acc = 0, cyc = 0, rv_at = 0, drv = 0, bad_a = 0;
    logic [DW-1:0] got = '0;
    int en;
    en = imax(imax(nz(c_aa), nz(c_ca)), nz(c_oa));
    for (int k = 0; k < 100; k++) begin
      cyc++;
      if (mem_addr !== a) bad_a++;
      if (!mem_oe_n) acc++;
      if (mem_dq_oe) drv++;
      if (rd_valid) begin rv_at = cyc; got = rd_data; end
      if (done) break;
      @(negedge clk);
    end
    chk("R7", {tag, " access cycles"}, acc, en);
    chk("R7", {tag, " rd_valid cycle"}, rv_at, en + 1);
    chk("R7", {tag, " read word"}, int'(got), int'(expd));
    chk("R8", {tag, " cycle length"}, cyc, imax(en + 1, nz(c_rc)));
    chk("R8", {tag, " address changes"}, bad_a, 0);
    chk("R9", {tag, " bus driven in read"}, drv, 0);
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1", "ce_n", int'(mem_ce_n), 1);
    chk("R1", "oe_n", int'(mem_oe_n), 1);
    chk("R1", "we_n", int'(mem_we_n), 1);
    chk("R1", "dq_oe", int'(mem_dq_oe), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "rd_valid", int'(rd_valid), 0);
    chk("R1", "req_ready", int'(req_ready), 1);
  endtask

  task automatic t_basic();
    set_cfg_w(2, 3, 2, 1, 0, 0);
    set_cfg_r(2, 1, 1, 0, 0);
    issue(1'b1, 16'h0003, 16'hA5C3);
    measure_write(16'h0003, 16'hA5C3, "basic write");
    need_acc = 2;
    issue(1'b0, 16'h0003, 16'h0);
    measure_read(16'h0003, 16'hA5C3, "basic read");
  endtask

  task automatic t_cs_stretch();
    set_cfg_w(1, 1, 1, 2, 6, 0);
    issue(1'b1, 16'h0005, 16'h1234);
    measure_write(16'h0005, 16'h1234, "cs-min write");
  endtask

  task automatic t_data_setup_and_cycle();
    set_cfg_w(1, 1, 4, 0, 0, 12);
    issue(1'b1, 16'h0007, 16'h0F0F);
    measure_write(16'h0007, 16'h0F0F, "long write cycle");
  endtask

  task automatic t_zeros_R6();
    set_cfg_w(0, 0, 0, 0, 0, 0);
    set_cfg_r(0, 0, 0, 0, 0);
    issue(1'b1, 16'h0009, 16'hBEEF);
    measure_write(16'h0009, 16'hBEEF, "R6 zero write");
    need_acc = 1;
    issue(1'b0, 16'h0009, 16'h0);
    measure_read(16'h0009, 16'hBEEF, "R6 zero read");
  endtask

  task automatic t_read_access();
    set_cfg_r(3, 5, 2, 0, 0);
    need_acc = 5;
    issue(1'b0, 16'h0005, 16'h0);
    measure_read(16'h0005, 16'h1234, "slowest access read");
    set_cfg_r(1, 2, 1, 10, 0);
    need_acc = 2;
    issue(1'b0, 16'h0007, 16'h0);
    measure_read(16'h0007, 16'h0F0F, "padded read");
  endtask

  task automatic t_turnaround_R10();
    int waited = 0;
    set_cfg_r(1, 1, 1, 0, 3);
    set_cfg_w(1, 1, 1, 1, 0, 0);
    need_acc = 1;
    issue(1'b0, 16'h0003, 16'h0);
    measure_read(16'h0003, 16'hA5C3, "pre-turnaround read");
    // now in the first cycle after done
    req_addr = 16'h000B; req_wdata = 16'h6789;
    req_write = 1'b0; #1;
    chk("R10", "read ready in turnaround", int'(req_ready), 1);
    req_write = 1'b1; req_valid = 1'b1; #1;
    for (int g = 0; g < 50 && !req_ready; g++) begin
      waited++;
      @(negedge clk);
    end
    chk("R10", "write hold-off cycles", waited, 3);
    @(negedge clk);
    req_valid = 1'b0;
    measure_write(16'h000B, 16'h6789, "post-turnaround write");
  endtask

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = 16'(i * 16'h0101);
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_cs_stretch();
    t_data_setup_and_cycle();
    t_zeros_R6();
    t_read_access();
    t_turnaround_R10();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule